// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits at the data-bus side of an eight-input interrupt controller. It answers the processor's interrupt acknowledge strobes and places the right byte on the bus for each one. The priority logic chooses the request level. Initialization decoding supplies the protocol mode, the call interval and the programmed address bits. The sequencer counts acknowledge pulses and decides which pulses carry data. It formats each byte and tells the rest of the controller when to freeze its request state and which level to put on the cascade lines.

Two protocols are supported. In call mode each acknowledge takes three pulses: an opcode byte, then a low address byte with the level number inside it, then the programmed high address byte. The bit position of the level number depends on the call interval. In vectored mode only two pulses occur. The first pulse drives nothing. The second pulse returns a single byte made of the upper programmed address bits and the level number. The strobe `ack_n` is expected to be already synchronous to `clk`. All outputs are plain control and data pins and have no handshake, because the processor's strobe sets the pace and cannot be held back.

Top module: `ack_vector_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `bus_oe`, `freeze`, `cas_valid` and `cas_code` are all 0 and the next acknowledge pulse is treated as the first of a sequence.
- R2: In call mode (`vect_mode`=0), the first pulse of a sequence drives 8'hCD with `bus_oe` high.
- R3: In call mode with interval 4 (`ival8`=0), the second pulse drives `{lo_addr[7:5], level, 2'b00}`.
- R4: In call mode with interval 8 (`ival8`=1), the second pulse drives `{lo_addr[7:6], level, 3'b000}`.
- R5: In call mode, the third pulse drives `hi_addr[7:0]` and ends the sequence, so that a fourth pulse is again a first pulse (8'hCD).
- R6: In vectored mode (`vect_mode`=1), `bus_oe` stays 0 throughout the first pulse.
- R7: In vectored mode, the second pulse drives `{hi_addr[7:3], level}` whatever the value of `ival8`, and ends the sequence.
- R8: `freeze` is high for exactly one cycle: the cycle after the clock edge that first samples `ack_n` low in a sequence. No later pulse of the sequence raises it again.
- R9: When `is_master`=1, `cas_valid` rises in the cycle after the clock edge that samples the end of the first pulse, with `cas_code` equal to the latched level. Both return to 0 when the sequence ends. When `is_master`=0, `cas_valid` stays 0.
- R10: The level is captured at the freeze point. A change on `level` later in the sequence does not alter the bytes or the cascade code.
- R11: `bus_oe` is high only while `ack_n` is low, and it drops in the same cycle that `ack_n` returns high.
- R12: A synchronous reset in the middle of a sequence returns the block to idle, so that the next pulse gets first-pulse treatment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_n | input | 1 | Acknowledge strobe, active low, synchronous to clk |
| level | input | 3 | Resolved interrupt level from the priority logic |
| vect_mode | input | 1 | 0: three-pulse call protocol, 1: two-pulse vectored protocol |
| ival8 | input | 1 | Call interval: 0 selects 4, 1 selects 8 |
| is_master | input | 1 | Enables the cascade code output |
| lo_addr | input | 8 | Programmed low address byte (upper bits used) |
| hi_addr | input | 8 | Programmed high address byte |
| bus_data | output | 8 | Byte for the data bus |
| bus_oe | output | 1 | Data bus output enable |
| freeze | output | 1 | One-cycle pulse that freezes the request state |
| cas_code | output | 3 | Cascade level code |
| cas_valid | output | 1 | Cascade code is being issued |

## Verification
Two events can coincide. The cycle that captures the end of the first pulse is the cycle in which the cascade code starts. In vectored mode that same pulse count also decides that the next pulse is the last one. The bench runs a master in vectored mode and checks, one cycle after the strobe goes high, that the code has appeared while the bus stays undriven. It then checks that the second pulse still produces the vectored byte and clears the cascade output. A second coincidence is a level change that lands after the freeze: the captured value must win in both the low address byte and the cascade code.

// File: rtl/ack_seq_pkg.sv
package ack_seq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } phase_e;

  typedef enum logic {
    PROTO_CALL = 1'b0,
    PROTO_VECT = 1'b1
  } proto_e;
endpackage

// File: rtl/ack_strobe_edge.sv
module ack_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic fall,
  output logic rise
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_n;
  end

  assign fall = ack_q & ~ack_n;
  assign rise = ~ack_q & ack_n;

  assert_edges_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && rise));
endmodule

// File: rtl/ack_phase_count.sv
module ack_phase_count
  import ack_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fall,
  input  logic   rise,
  input  logic   proto_in,
  output phase_e phase,
  output proto_e proto_eff,
  output logic   idle,
  output logic   last_rise
);
  phase_e phase_q;
  proto_e proto_q;

  assign idle      = (phase_q == PH_FIRST);
  assign proto_eff = idle ? proto_e'(proto_in) : proto_q;
  assign last_rise = rise && (((proto_eff == PROTO_VECT) && (phase_q == PH_SECOND)) ||
                              ((proto_eff == PROTO_CALL) && (phase_q == PH_THIRD)));
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      proto_q <= PROTO_CALL;
    end else begin
      if (fall && idle) proto_q <= proto_e'(proto_in);
      if (last_rise)    phase_q <= PH_FIRST;
      else if (rise)    phase_q <= phase_e'(phase_q + 2'd1);
    end
  end

  assert_third_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && phase_q == PH_THIRD) |=> (phase_q == PH_FIRST));

  assert_vect_two_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_q == PROTO_VECT && !idle) |-> (phase_q != PH_THIRD));

  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |=> (phase_q == PH_FIRST));
endmodule

// File: rtl/ack_byte_format.sv
module ack_byte_format
  import ack_seq_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned LVW = 3
) (
  input  phase_e          phase,
  input  proto_e          proto,
  input  logic            ival8,
  input  logic [LVW-1:0]  lvl,
  input  logic [DW-1:0]   lo_addr,
  input  logic [DW-1:0]   hi_addr,
  output logic [DW-1:0]   byte_out,
  output logic            carries_data
);
  localparam int unsigned Z4  = 2;
  localparam int unsigned Z8  = 3;
  localparam int unsigned U4  = DW - LVW - Z4;
  localparam int unsigned U8  = DW - LVW - Z8;
  localparam int unsigned UV  = DW - LVW;

  logic [DW-1:0] lo_i4, lo_i8, vec_b, low_b;
  logic          unused_lo;

  assign lo_i4 = {lo_addr[DW-1 -: U4], lvl, {Z4{1'b0}}};
  assign lo_i8 = {lo_addr[DW-1 -: U8], lvl, {Z8{1'b0}}};
  assign vec_b = {hi_addr[DW-1 -: UV], lvl};
  assign unused_lo = ^lo_addr[DW-U4-1:0];

  generate
    if (U8 >= 1) begin : g_two_intervals
      assign low_b = ival8 ? lo_i8 : lo_i4;
    end else begin : g_only_int4
      assign low_b = lo_i4;
    end
  endgenerate

  always_comb begin
    byte_out     = '0;
    carries_data = 1'b0;
    unique case (phase)
      PH_FIRST: begin
        if (proto == PROTO_CALL) begin
          byte_out     = CALL_OPCODE;
          carries_data = 1'b1;
        end
      end
      PH_SECOND: begin
        byte_out     = (proto == PROTO_VECT) ? vec_b : low_b;
        carries_data = 1'b1;
      end
      PH_THIRD: begin
        byte_out     = hi_addr;
        carries_data = (proto == PROTO_CALL);
      end
      default: begin
        byte_out     = '0;
        carries_data = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ack_vector_seq.sv
module ack_vector_seq
  import ack_seq_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned LVW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_n,
  input  logic [LVW-1:0] level,
  input  logic           vect_mode,
  input  logic           ival8,
  input  logic           is_master,
  input  logic [DW-1:0]  lo_addr,
  input  logic [DW-1:0]  hi_addr,
  output logic [DW-1:0]  bus_data,
  output logic           bus_oe,
  output logic           freeze,
  output logic [LVW-1:0] cas_code,
  output logic           cas_valid
);
  logic           fall, rise, idle, last_rise, carries;
  phase_e         phase;
  proto_e         proto;
  logic [LVW-1:0] lvl_q;
  logic           freeze_q, cas_q;

  ack_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ack_n (ack_n),
    .fall  (fall),
    .rise  (rise)
  );

  ack_phase_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .rise      (rise),
    .proto_in  (vect_mode),
    .phase     (phase),
    .proto_eff (proto),
    .idle      (idle),
    .last_rise (last_rise)
  );

  ack_byte_format #(.DW(DW), .LVW(LVW)) u_fmt (
    .phase        (phase),
    .proto        (proto),
    .ival8        (ival8),
    .lvl          (lvl_q),
    .lo_addr      (lo_addr),
    .hi_addr      (hi_addr),
    .byte_out     (bus_data),
    .carries_data (carries)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      freeze_q <= 1'b0;
      cas_q    <= 1'b0;
    end else begin
      freeze_q <= fall && idle;
      if (fall && idle) lvl_q <= level;
      if (last_rise)
        cas_q <= 1'b0;
      else if (rise && idle && is_master)
        cas_q <= 1'b1;
    end
  end

  assign bus_oe    = ~ack_n & carries;
  assign freeze    = freeze_q;
  assign cas_valid = cas_q;
  assign cas_code  = cas_q ? lvl_q : '0;

  assert_oe_only_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !ack_n);

  assert_freeze_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !freeze);

  assert_vect_first_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && vect_mode) |-> !bus_oe);

  assert_level_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(lvl_q));

  assert_cas_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_valid && $past(cas_valid)) |-> $stable(cas_code));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!freeze && !cas_valid));
endmodule

// File: tb/test_ack_vector_seq.sv
module test_ack_vector_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_n = 1'b1;
  logic [2:0] level = '0;
  logic       vect_mode = 1'b0;
  logic       ival8 = 1'b0;
  logic       is_master = 1'b0;
  logic [7:0] lo_addr = '0;
  logic [7:0] hi_addr = '0;
  logic [7:0] bus_data;
  logic       bus_oe, freeze, cas_valid;
  logic [2:0] cas_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ack_vector_seq i_ack_vector_seq (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .level(level),
    .vect_mode(vect_mode), .ival8(ival8), .is_master(is_master),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .bus_data(bus_data),
    .bus_oe(bus_oe), .freeze(freeze), .cas_code(cas_code), .cas_valid(cas_valid)
  );

  // {vect, ival8, level, lo_addr, hi_addr, byte1, byte2, byte3, oe mask [p3 p2 p1]}
  localparam logic [47:0] VECS [6] = '{
    {1'b0, 1'b0, 3'd5, 8'hA0, 8'h12, 8'hCD, 8'hB4, 8'h12, 3'b111},
    {1'b0, 1'b1, 3'd3, 8'hC0, 8'h3F, 8'hCD, 8'hD8, 8'h3F, 3'b111},
    {1'b0, 1'b0, 3'd0, 8'h1F, 8'h00, 8'hCD, 8'h00, 8'h00, 3'b111},
    {1'b0, 1'b1, 3'd7, 8'h3F, 8'hFF, 8'hCD, 8'h38, 8'hFF, 3'b111},
    {1'b1, 1'b0, 3'd6, 8'h00, 8'hA8, 8'h00, 8'hAE, 8'h00, 3'b010},
    {1'b1, 1'b1, 3'd1, 8'hFF, 8'h57, 8'h00, 8'h51, 8'h00, 3'b010}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one acknowledge pulse; starts and ends on a falling clock edge
  task automatic pulse(output logic [7:0] d, output logic oe, output logic fr1,
                       output logic fr2, output logic oe_hi, output logic cv,
                       output logic [2:0] cc);
    ack_n = 1'b0;
    @(negedge clk);
    d = bus_data; oe = bus_oe; fr1 = freeze;
    @(negedge clk);
    fr2 = freeze;
    ack_n = 1'b1;
    @(negedge clk);
    oe_hi = bus_oe; cv = cas_valid; cc = cas_code;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, f1, f2, oeh, cv;
    logic [2:0] cc;

    @(negedge clk);
    @(negedge clk);
    check("R1 oe", {7'd0, bus_oe}, 8'd0);
    check("R1 freeze", {7'd0, freeze}, 8'd0);
    check("R1 cas_valid", {7'd0, cas_valid}, 8'd0);
    check("R1 cas_code", {5'd0, cas_code}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    foreach (VECS[i]) begin
      logic [47:0] v;
      v = VECS[i];
      vect_mode = v[47]; ival8 = v[46]; level = v[45:43];
      lo_addr = v[42:35]; hi_addr = v[34:27];
      for (int p = 0; p < (v[47] ? 2 : 3); p++) begin
        pulse(d, oe, f1, f2, oeh, cv, cc);
        check(v[47] ? "R6/R7 oe" : "R2/R5 oe", {7'd0, oe}, {7'd0, v[p]});
        if (v[p]) check(p == 0 ? "R2 byte" : (p == 1 ? (v[47] ? "R7 byte" : (v[46] ? "R4 byte" : "R3 byte")) : "R5 byte"),
                        d, v[26 - 8*p -: 8]);
        check("R11 oe after rise", {7'd0, oeh}, 8'd0);
      end
    end

    // R5: fourth call pulse starts a new sequence
    vect_mode = 1'b0; ival8 = 1'b0; level = 3'd2; lo_addr = 8'h00; hi_addr = 8'h44;
    for (int p = 0; p < 3; p++) pulse(d, oe, f1, f2, oeh, cv, cc);
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R5 restart byte", d, 8'hCD);
    check("R8 freeze on new first", {7'd0, f1}, 8'd1);
    check("R8 freeze one cycle", {7'd0, f2}, 8'd0);
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R8 no freeze on second", {7'd0, f1}, 8'd0);
    pulse(d, oe, f1, f2, oeh, cv, cc);

    // R9: master in vectored mode; cascade and end-of-sequence together
    is_master = 1'b1; vect_mode = 1'b1; level = 3'd4; hi_addr = 8'hF8;
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R9 cas_valid after first", {7'd0, cv}, 8'd1);
    check("R9 cas_code", {5'd0, cc}, 8'd4);
    check("R6 no oe with cascade", {7'd0, oe}, 8'd0);
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R7 byte with cascade", d, 8'hFC);
    check("R9 cas cleared", {7'd0, cv}, 8'd0);
    is_master = 1'b0;
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R9 slave no cascade", {7'd0, cv}, 8'd0);
    pulse(d, oe, f1, f2, oeh, cv, cc);

    // R10: level change after freeze is ignored
    is_master = 1'b1; vect_mode = 1'b0; ival8 = 1'b0; level = 3'd2; lo_addr = 8'h00;
    pulse(d, oe, f1, f2, oeh, cv, cc);
    level = 3'd7;
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R10 held level byte", d, 8'h08);
    check("R10 held cascade", {5'd0, cc}, 8'd2);
    pulse(d, oe, f1, f2, oeh, cv, cc);
    is_master = 1'b0;

    // R12: reset mid-sequence
    level = 3'd1;
    pulse(d, oe, f1, f2, oeh, cv, cc);
    do_reset();
    pulse(d, oe, f1, f2, oeh, cv, cc);
    check("R12 first after reset", d, 8'hCD);
    check("R12 freeze after reset", {7'd0, f1}, 8'd1);
    do_reset();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule